// File: doc/BRIEF.md
# Three-Source Divided Clock-Enable Selector

This block turns three free-running source enable streams into one divided enable stream per output channel. All of it runs in a single system clock domain: a source "clock" is a one-cycle tick on `src_tick`, and each channel output `ch_en` is a one-cycle tick. For each channel, software picks which of the three sources it follows and sets a separate 5-bit divide ratio for every source. A fourth select code turns the channel off.

Software reaches the block through a flat 32-bit register port with a combinational read. Select fields can only be changed through a command word. That word either selects a source or switches the channel off. An attempt to select the nonexistent fourth source is dropped. Each source also has a status word with one running bit per channel. The bit is set only when that source is selected and the channel has produced its first output tick since it was last restarted. Software polls this bit after a change to learn when the new path is live.

Top module: `clkdiv_top`

## Requirements
- R1: After reset every select field reads 3 (off), every divider word reads 0, every status word reads 0 and `ch_en` is low.
- R2: A write to the command word at offset 0x008 carries the channel number in bits 11:8, an off flag in bit 2 and a source code in bits 1:0. With the off flag set the channel's select field becomes 3. Otherwise, source code 0, 1 or 2 becomes the select field.
- R3: A command write with the off flag clear and source code 3 is rejected: no select field changes and no channel restarts.
- R4: Channel n's 2-bit select field sits at bit position SEL_START+2n of the word at offset 0x000. A position of 32 or more instead sits at that position minus 32 in the word at offset 0x004. The default SEL_START is 28.
- R5: Source s keeps one divider word per channel at offset 0x100·(s+1)+4n. Only bits 4:0 are stored, and they read back with all upper bits zero.
- R6: With source s selected and divider value k, a channel raises `ch_en` for one cycle once every k+1 ticks of source s, counted from the last restart. Ticks of the other sources have no effect. The pulse appears in the cycle after the tick that completes the count.
- R7: A channel whose select field is 3 never raises `ch_en`.
- R8: The status word of source s is at offset 0x010+4s. Bit STAT_BIT0+n (default STAT_BIT0 is 4) is 1 only when channel n selects s and is running. All other bits read 0.
- R9: An accepted command for a channel, or a write to the divider word of the channel's currently selected source, restarts that channel: its count starts over and its running bit reads 0. The running bit returns to 1 with the first output pulse after the restart. A write to a divider of an unselected source does not restart the channel.
- R10: A command that moves a running channel to another source takes effect at once. Counting then uses the newly selected source's ticks and that source's divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 3 | One-cycle enable ticks of the three sources |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (12) | Byte address for both read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| ch_en | output | NCH (4) | Divided enable tick per channel |

## Verification
The assertions take for granted that the source ticks and register writes are synchronous to `clk` and hold steady across each edge. They also assume at most one register write per cycle, so that a rejected command can be checked against an unchanged select vector. The stimulus drives every input on the falling edge and issues writes one at a time. Before each measured window it restarts every channel and holds the ticks low, so the pulse count of a window depends only on the ticks given inside it. Random rounds mix tick densities from sparse to every cycle, random divider words carrying junk upper bits, rejected commands and off commands.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   localparam int SRC_N   = 3;
   localparam int CODE_W  = 2;
   localparam int RATIO_W = 5;

   typedef logic [CODE_W-1:0]  sel_code_t;
   typedef logic [RATIO_W-1:0] ratio_t;

   localparam sel_code_t CODE_OFF = 2'd3;

   function automatic logic code_is_source(sel_code_t c);
      return c != CODE_OFF;
   endfunction

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
   import clkdiv_pkg::*;
#(
   parameter int                NCH       = 4,
   parameter int                SEL_START = 28,
   parameter int                STAT_BIT0 = 4,
   parameter int                ADDR_W    = 12,
   parameter logic [ADDR_W-1:0] SEL_ADDR0 = 12'h000,
   parameter logic [ADDR_W-1:0] SEL_ADDR1 = 12'h004,
   parameter logic [ADDR_W-1:0] CMD_ADDR  = 12'h008,
   parameter logic [ADDR_W-1:0] STAT_BASE = 12'h010,
   parameter logic [ADDR_W-1:0] DIV_BASE0 = 12'h100,
   parameter logic [ADDR_W-1:0] DIV_BASE1 = 12'h200,
   parameter logic [ADDR_W-1:0] DIV_BASE2 = 12'h300
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wr_data,
   input  logic [NCH-1:0]    run_vec,
   output logic [31:0]       rd_data,
   output sel_code_t         sel_q    [NCH],
   output ratio_t            ch_ratio [NCH][SRC_N],
   output logic [NCH-1:0]    restart_vec
);

   localparam int CH_FIELD_LO = 8;
   localparam int CH_FIELD_W  = 4;
   localparam int OFF_BIT     = 2;

   function automatic logic [ADDR_W-1:0] div_addr(int s, int n);
      logic [ADDR_W-1:0] base;
      case (s)
         0:       base = DIV_BASE0;
         1:       base = DIV_BASE1;
         default: base = DIV_BASE2;
      endcase
      return base + ADDR_W'(4 * n);
   endfunction

   // command decode
   logic                  cmd_hit;
   logic                  cmd_ok;
   logic [CH_FIELD_W-1:0] cmd_ch;
   sel_code_t             cmd_code;
   logic                  unused_wdata;

   assign cmd_hit  = wr_en && (addr == CMD_ADDR);
   assign cmd_ch   = wr_data[CH_FIELD_LO +: CH_FIELD_W];
   assign cmd_code = wr_data[OFF_BIT] ? CODE_OFF : wr_data[CODE_W-1:0];
   assign cmd_ok   = cmd_hit && (32'(cmd_ch) < NCH) &&
                     (wr_data[OFF_BIT] || code_is_source(wr_data[CODE_W-1:0]));
   assign unused_wdata = ^{wr_data[31:CH_FIELD_LO+CH_FIELD_W],
                           wr_data[CH_FIELD_LO-1:OFF_BIT+1]};

   // divider word decode
   logic div_hit [SRC_N][NCH];

   for (genvar s = 0; s < SRC_N; s++) begin : g_div_src
      for (genvar n = 0; n < NCH; n++) begin : g_div_ch
         assign div_hit[s][n] = wr_en && (addr == div_addr(s, n));
      end
   end

   // state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int n = 0; n < NCH; n++) begin
            sel_q[n] <= CODE_OFF;
            for (int s = 0; s < SRC_N; s++) ch_ratio[n][s] <= '0;
         end
      end else begin
         for (int n = 0; n < NCH; n++) begin
            if (cmd_ok && (cmd_ch == CH_FIELD_W'(n))) sel_q[n] <= cmd_code;
            for (int s = 0; s < SRC_N; s++)
               if (div_hit[s][n]) ch_ratio[n][s] <= wr_data[RATIO_W-1:0];
         end
      end
   end

   // restart requests toward the channels
   always_comb begin
      for (int n = 0; n < NCH; n++) begin
         restart_vec[n] = cmd_ok && (cmd_ch == CH_FIELD_W'(n));
         for (int s = 0; s < SRC_N; s++)
            if (div_hit[s][n] && (sel_q[n] == CODE_W'(s))) restart_vec[n] = 1'b1;
      end
   end

   // read path
   logic [31:0] sel_w0, sel_w1;
   logic [31:0] stat_w [SRC_N];
   logic [5:0]  fpos;

   always_comb begin
      sel_w0 = '0;
      sel_w1 = '0;
      fpos   = '0;
      for (int n = 0; n < NCH; n++) begin
         fpos = 6'(SEL_START + 2 * n);
         if (!fpos[5]) sel_w0[fpos[4:0] +: CODE_W] = sel_q[n];
         else          sel_w1[fpos[4:0] +: CODE_W] = sel_q[n];
      end
   end

   always_comb begin
      for (int s = 0; s < SRC_N; s++) begin
         stat_w[s] = '0;
         for (int n = 0; n < NCH; n++)
            stat_w[s][5'(STAT_BIT0 + n)] = run_vec[n] && (sel_q[n] == CODE_W'(s));
      end
   end

   always_comb begin
      rd_data = '0;
      if (addr == SEL_ADDR0) rd_data = sel_w0;
      if (addr == SEL_ADDR1) rd_data = sel_w1;
      for (int s = 0; s < SRC_N; s++) begin
         if (addr == STAT_BASE + ADDR_W'(4 * s)) rd_data = stat_w[s];
         for (int n = 0; n < NCH; n++)
            if (addr == div_addr(s, n)) rd_data = 32'(ch_ratio[n][s]);
      end
   end

endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan
   import clkdiv_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_N-1:0] src_tick,
   input  sel_code_t        sel_code,
   input  ratio_t           ratio [SRC_N],
   input  logic             restart,
   output logic             ch_en,
   output logic             running
);

   logic   tick;
   ratio_t limit;
   ratio_t cnt_q;

   // source and ratio follow the select code together
   always_comb begin
      tick  = 1'b0;
      limit = '0;
      case (sel_code)
         2'd0:    begin tick = src_tick[0]; limit = ratio[0]; end
         2'd1:    begin tick = src_tick[1]; limit = ratio[1]; end
         2'd2:    begin tick = src_tick[2]; limit = ratio[2]; end
         default: begin tick = 1'b0;        limit = '0;       end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         ch_en   <= 1'b0;
         running <= 1'b0;
      end else begin
         ch_en <= 1'b0;
         if (restart) begin
            cnt_q   <= '0;
            running <= 1'b0;
         end else if (tick) begin
            if (cnt_q == limit) begin
               cnt_q   <= '0;
               ch_en   <= 1'b1;
               running <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
   import clkdiv_pkg::*;
#(
   parameter int                NCH       = 4,
   parameter int                SEL_START = 28,
   parameter int                STAT_BIT0 = 4,
   parameter int                ADDR_W    = 12,
   parameter logic [ADDR_W-1:0] SEL_ADDR0 = 12'h000,
   parameter logic [ADDR_W-1:0] SEL_ADDR1 = 12'h004,
   parameter logic [ADDR_W-1:0] CMD_ADDR  = 12'h008,
   parameter logic [ADDR_W-1:0] STAT_BASE = 12'h010,
   parameter logic [ADDR_W-1:0] DIV_BASE0 = 12'h100,
   parameter logic [ADDR_W-1:0] DIV_BASE1 = 12'h200,
   parameter logic [ADDR_W-1:0] DIV_BASE2 = 12'h300
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        src_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wr_data,
   output logic [31:0]       rd_data,
   output logic [NCH-1:0]    ch_en
);

   localparam int SEL_END = SEL_START + CODE_W * NCH;
   localparam int DIV_SPAN = 4 * NCH;

   // elaboration-time parameter checks
   if (NCH < 1 || NCH > 16) begin : g_bad_nch
      $error("clkdiv_top: NCH must lie in 1..16");
   end
   if ((SEL_START % 2) != 0 || SEL_END > 64) begin : g_bad_sel
      $error("clkdiv_top: select fields must be even-aligned and fit two words");
   end
   if (STAT_BIT0 + NCH > 32) begin : g_bad_stat
      $error("clkdiv_top: status bits exceed one word");
   end
   if (int'(DIV_BASE1) - int'(DIV_BASE0) < DIV_SPAN ||
       int'(DIV_BASE2) - int'(DIV_BASE1) < DIV_SPAN) begin : g_bad_div
      $error("clkdiv_top: divider banks overlap");
   end

   sel_code_t          sel_q    [NCH];
   ratio_t             ch_ratio [NCH][SRC_N];
   logic [NCH-1:0]     restart_vec;
   logic [NCH-1:0]     run_vec;
   logic [2*NCH-1:0]   sel_flat;

   clkdiv_regs #(
      .NCH(NCH), .SEL_START(SEL_START), .STAT_BIT0(STAT_BIT0), .ADDR_W(ADDR_W),
      .SEL_ADDR0(SEL_ADDR0), .SEL_ADDR1(SEL_ADDR1), .CMD_ADDR(CMD_ADDR),
      .STAT_BASE(STAT_BASE), .DIV_BASE0(DIV_BASE0), .DIV_BASE1(DIV_BASE1),
      .DIV_BASE2(DIV_BASE2)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .addr       (addr),
      .wr_data    (wr_data),
      .run_vec    (run_vec),
      .rd_data    (rd_data),
      .sel_q      (sel_q),
      .ch_ratio   (ch_ratio),
      .restart_vec(restart_vec)
   );

   for (genvar n = 0; n < NCH; n++) begin : g_chan
      clkdiv_chan u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .src_tick(src_tick),
         .sel_code(sel_q[n]),
         .ratio   (ch_ratio[n]),
         .restart (restart_vec[n]),
         .ch_en   (ch_en[n]),
         .running (run_vec[n])
      );
      assign sel_flat[CODE_W*n +: CODE_W] = sel_q[n];
   end

endmodule

// File: rtl/clkdiv_top_chk.sv
module clkdiv_top_chk #(
   parameter int                NCH      = 4,
   parameter int                ADDR_W   = 12,
   parameter logic [ADDR_W-1:0] CMD_ADDR = 12'h008
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [31:0]       wr_data,
   input logic [2:0]        src_tick,
   input logic [NCH-1:0]    ch_en,
   input logic [2*NCH-1:0]  sel_flat,
   input logic [NCH-1:0]    run_vec,
   input logic [NCH-1:0]    restart_vec
);

   logic unused_hi;
   assign unused_hi = ^wr_data[31:3];

   // R1: select fields hold the off code while and just after reset
   p_reset_off_r1: assert property (@(posedge clk)
      !rst_n |=> (sel_flat == {NCH{2'b11}}));

   // R3: an illegal source code leaves every select field alone
   p_reject_code3_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == CMD_ADDR && !wr_data[2] && wr_data[1:0] == 2'd3)
      |=> $stable(sel_flat));

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      // R7: an off channel stays silent
      p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_flat[2*n +: 2] == 2'd3) |=> !ch_en[n]);

      // R6: every output pulse follows a source tick
      p_pulse_after_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
         ch_en[n] |-> $past(src_tick != 3'b000));

      // R9: a pulse always leaves the channel running
      p_pulse_sets_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
         ch_en[n] |-> run_vec[n]);

      // R9: a restart clears running and suppresses the pulse
      p_restart_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
         restart_vec[n] |=> (!run_vec[n] && !ch_en[n]));
   end

endmodule

bind clkdiv_top clkdiv_top_chk #(
   .NCH(NCH), .ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .addr       (addr),
   .wr_data    (wr_data),
   .src_tick   (src_tick),
   .ch_en      (ch_en),
   .sel_flat   (sel_flat),
   .run_vec    (run_vec),
   .restart_vec(restart_vec)
);

// File: tb/clkdiv_top_test.sv
module clkdiv_top_test;

   localparam int NCH = 4;
   localparam logic [11:0] A_SEL0 = 12'h000;
   localparam logic [11:0] A_SEL1 = 12'h004;
   localparam logic [11:0] A_CMD  = 12'h008;
   localparam logic [11:0] A_STAT = 12'h010;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [2:0]      src_tick;
   logic            wr_en;
   logic [11:0]     addr;
   logic [31:0]     wr_data;
   logic [31:0]     rd_data;
   logic [NCH-1:0]  ch_en;

   int errors = 0;
   int checks = 0;
   int pulses [NCH];
   int ticks  [3];
   logic [1:0] m_sel [NCH];
   logic [4:0] m_div [3][NCH];
   bit finished = 0;

   always #4 clk = ~clk;

   clkdiv_top uut (
      .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
      .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .ch_en(ch_en)
   );

   always @(negedge clk)
      if (rst_n === 1'b1)
         for (int n = 0; n < NCH; n++) if (ch_en[n]) pulses[n]++;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [11:0] div_addr(int s, int n);
      return 12'(12'h100 * (s + 1) + 4 * n);
   endfunction

   function automatic logic [31:0] exp_sel(int w);
      logic [31:0] r = '0;
      for (int n = 0; n < NCH; n++) begin
         int p = 28 + 2 * n;
         if (p / 32 == w) r[p % 32 +: 2] = m_sel[n];
      end
      return r;
   endfunction

   function automatic logic [31:0] exp_stat(int s);
      logic [31:0] r = '0;
      for (int n = 0; n < NCH; n++)
         if (m_sel[n] == 2'(s) && pulses[n] > 0) r[4 + n] = 1'b1;
      return r;
   endfunction

   function automatic int exp_pulses(int n);
      if (m_sel[n] == 2'd3) return 0;
      return ticks[m_sel[n]] / (int'(m_div[m_sel[n]][n]) + 1);
   endfunction

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] v);
      @(negedge clk);
      addr = a;
      #1 v = rd_data;
   endtask

   task automatic cmd(input int ch, input bit off, input logic [1:0] code);
      wr(A_CMD, {20'($urandom) & 20'h0, 4'(ch), 5'b0, off, code});
      if (off) m_sel[ch] = 2'd3;
      else if (code != 2'd3) m_sel[ch] = code;
   endtask

   task automatic set_div(input int s, input int n, input logic [4:0] v);
      wr(div_addr(s, n), {$urandom} & 32'hFFFF_FFE0 | 32'(v));
      m_div[s][n] = v;
   endtask

   task automatic clear_counts();
      for (int n = 0; n < NCH; n++) pulses[n] = 0;
      for (int s = 0; s < 3; s++) ticks[s] = 0;
   endtask

   task automatic run(input int cycles, input int dens);
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         for (int s = 0; s < 3; s++) begin
            src_tick[s] = ($urandom_range(99) < dens);
            if (src_tick[s]) ticks[s]++;
         end
      end
      @(negedge clk);
      src_tick = 3'b000;
      repeat (3) @(negedge clk);
   endtask

   task automatic check_sel(input string tag);
      logic [31:0] v;
      rd(A_SEL0, v); chk({tag, " sel word0"}, v, exp_sel(0));
      rd(A_SEL1, v); chk({tag, " sel word1"}, v, exp_sel(1));
   endtask

   task automatic check_round(input string tag);
      logic [31:0] v;
      for (int n = 0; n < NCH; n++)
         chk($sformatf("%s R6/R7/R10 ch%0d pulses", tag, n), 32'(pulses[n]), 32'(exp_pulses(n)));
      for (int s = 0; s < 3; s++) begin
         rd(A_STAT + 12'(4 * s), v);
         chk($sformatf("%s R8 status src%0d", tag, s), v, exp_stat(s));
      end
      check_sel({tag, " R2/R4"});
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd4242));
      rst_n = 1'b0; src_tick = '0; wr_en = 1'b0; addr = '0; wr_data = '0;
      for (int n = 0; n < NCH; n++) begin
         m_sel[n] = 2'd3;
         for (int s = 0; s < 3; s++) m_div[s][n] = '0;
      end
      clear_counts();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      chk("R1 ch_en", 32'(ch_en), 32'h0);
      rd(A_SEL0, v); chk("R1/R4 sel word0", v, 32'hF000_0000);
      rd(A_SEL1, v); chk("R1/R4 sel word1", v, 32'h0000_000F);
      for (int s = 0; s < 3; s++) begin
         rd(A_STAT + 12'(4 * s), v); chk("R1 status", v, 32'h0);
         for (int n = 0; n < NCH; n++) begin
            rd(div_addr(s, n), v); chk("R1 divider", v, 32'h0);
         end
      end

      // R5: divider words store five bits
      for (int s = 0; s < 3; s++)
         for (int n = 0; n < NCH; n++) set_div(s, n, 5'($urandom));
      for (int s = 0; s < 3; s++)
         for (int n = 0; n < NCH; n++) begin
            rd(div_addr(s, n), v); chk("R5 divider readback", v, 32'(m_div[s][n]));
         end

      // ratio extremes with every-cycle ticks
      set_div(0, 0, 5'd0);
      set_div(1, 1, 5'd31);
      set_div(2, 2, 5'd5);
      cmd(0, 0, 2'd0); cmd(1, 0, 2'd1); cmd(2, 0, 2'd2); cmd(3, 1, 2'd0);
      for (int s = 0; s < 3; s++) begin
         rd(A_STAT + 12'(4 * s), v); chk("R9 status clear after select", v, 32'h0);
      end
      clear_counts();
      run(200, 100);
      chk("R6 divide by 1", 32'(pulses[0]), 32'd200);
      chk("R6 divide by 32", 32'(pulses[1]), 32'd6);
      chk("R6 divide by 6", 32'(pulses[2]), 32'd33);
      chk("R7 off channel", 32'(pulses[3]), 32'd0);
      check_round("extremes");

      // R3: illegal source code rejected, running kept
      cmd(1, 0, 2'd3);
      check_sel("R3 reject");
      rd(A_STAT + 12'h4, v); chk("R3 no restart", v[5], 1'b1);

      // R9: unselected divider write keeps running, selected one restarts
      set_div(0, 1, 5'd7);
      rd(A_STAT + 12'h4, v); chk("R9 unselected div keeps run", v[5], 1'b1);
      set_div(1, 1, 5'd1);
      rd(A_STAT + 12'h4, v); chk("R9 selected div restarts", v[5], 1'b0);
      pulses[1] = 0; ticks[1] = 0;
      run(40, 100);
      chk("R9 count after div restart", 32'(pulses[1]), 32'd20);
      rd(A_STAT + 12'h4, v); chk("R9 running again", v[5], 1'b1);

      // R10: switch a running channel to another source
      set_div(2, 0, 5'd2);
      cmd(0, 0, 2'd2);
      rd(A_STAT + 12'h8, v); chk("R10 not yet running", v[4], 1'b0);
      for (int n = 1; n < NCH; n++) cmd(n, m_sel[n] == 2'd3, m_sel[n]);
      clear_counts();
      run(90, 100);
      chk("R10 new source divider", 32'(pulses[0]), 32'd30);
      check_round("switch");

      // random rounds
      for (int r = 0; r < 25; r++) begin
         for (int n = 0; n < NCH; n++) begin
            if ($urandom_range(2) == 0) set_div($urandom_range(2), n, 5'($urandom));
            if ($urandom_range(3) == 0) begin
               cmd(n, 0, 2'd3);
               check_sel("R3 random reject");
            end
            begin
               int pick = $urandom_range(3);
               cmd(n, pick == 3, 2'(pick));
            end
         end
         for (int s = 0; s < 3; s++) begin
            rd(A_STAT + 12'(4 * s), v); chk("R9 random status clear", v, 32'h0);
         end
         clear_counts();
         run(120, $urandom_range(10, 100));
         check_round($sformatf("round%0d", r));
      end

      finish_run();
   end

endmodule